// File: doc/BRIEF.md
# Machine Security Configuration Register

This block holds the machine-level security configuration word that steers a physical memory protection unit. It stores three control flags: a lockdown flag for machine mode, a default-deny (whitelist) policy flag for machine mode, and a bypass flag that allows locked protection rules to be edited. It sits on the core's CSR access path. It answers only at its configured CSR address, and it accepts an access only from machine privilege when the enhanced-protection strap is high. Any other access at its address raises an illegal-instruction indication and leaves the register untouched.

Writes pass through a filter before they are stored. Once the lockdown and whitelist flags are set, no write can clear them. The bypass flag cannot be raised from zero while any protection entry reports its lock bit. Once the bypass flag is set, software may keep it or drop it freely. The stored flags leave the block as level outputs. A one-cycle update strobe tells the downstream permission logic to re-evaluate after every legal write.

Top module: `secfg_ctrl_reg`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, the stored word reads as zero, all three flag outputs are 0 and cfg_update_o is 0.
- R2: Bit 0 (lockdown flag, cfg_lockdown_o) can be set by a legal write that has data bit 0 = 1. Once set, it stays 1 through any later write until reset.
- R3: Bit 1 (whitelist flag, cfg_whitelist_o) can be set by a legal write that has data bit 1 = 1. Once set, it stays 1 through any later write until reset.
- R4: When the stored bit 2 (bypass flag, cfg_bypass_o) is 0 and at least one bit of entry_lock_i is 1 in the write cycle, a legal write stores bit 2 as 0 whatever its data bit 2 is.
- R5: When the stored bypass flag is 1, or no entry lock bit is set, a legal write stores data bit 2 as given.
- R6: An access at the block's address is legal only when priv_i equals 2'b11 (machine) and feat_en_i is 1. Any other access at that address drives csr_illegal_o high in the same cycle and leaves the stored word unchanged.
- R7: During a legal access, csr_rdata_o shows the stored word combinationally. During a legal write it shows the value from before the write, and the new value appears after the next rising edge. In every other cycle csr_rdata_o is 0.
- R8: Bits XLEN-1 down to 3 are reserved. They are stored and read as 0 for any written value.
- R9: When csr_en_i is low, or csr_addr_i differs from CSR_ADDR, the block raises no illegal flag, drives csr_rdata_o to 0 and does not change the stored word.
- R10: cfg_update_o is 1 for exactly the one cycle after each legal write and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| csr_en_i | input | 1 | CSR access request in this cycle |
| csr_addr_i | input | ADDR_W | CSR address of the access |
| csr_we_i | input | 1 | Access is a write |
| csr_wdata_i | input | XLEN | Write data |
| csr_rdata_o | output | XLEN | Read data (0 unless a legal access hits) |
| csr_illegal_o | output | 1 | Illegal-instruction indication for a hitting access |
| priv_i | input | 2 | Current privilege level, 2'b11 is machine |
| feat_en_i | input | 1 | Enhanced-protection feature strap |
| entry_lock_i | input | NUM_ENTRIES | Lock bit of each protection entry |
| cfg_lockdown_o | output | 1 | Stored lockdown flag (bit 0) |
| cfg_whitelist_o | output | 1 | Stored whitelist policy flag (bit 1) |
| cfg_bypass_o | output | 1 | Stored rule-lock bypass flag (bit 2) |
| cfg_update_o | output | 1 | One-cycle strobe after a legal write |

## Verification
The bench builds the block with NUM_ENTRIES = 4 and XLEN = 32. With only four entries, every lock pattern (all 16) can be combined with all eight starting flag states and all eight written flag values. That sweep reaches every sticky and bypass case, including a blocked bypass set and a bypass clear followed by a re-set attempt. All four privilege codes are crossed with both strap values. Writes also carry set reserved bits and non-matching addresses, so the decode and masking paths are exercised too.

// File: rtl/secfg_pkg.sv
// Package: shared constants and the flag layout of the security configuration word.
// Assumes: the three flags occupy the low bits in the order that downstream decoders expect.
package secfg_pkg;

    localparam int FLAG_W = 3;
    localparam int BIT_LOCKDOWN  = 0;
    localparam int BIT_WHITELIST = 1;
    localparam int BIT_BYPASS    = 2;

    localparam logic [1:0] PRIV_MACHINE = 2'b11;

    // Packed view of the low flag bits; bypass is the MSB (bit 2)
    typedef struct packed {
        logic bypass;
        logic whitelist;
        logic lockdown;
    } secfg_flags_t;

endpackage

// File: rtl/secfg_access_gate.sv
// Module: secfg_access_gate
// Decodes the CSR address and decides whether a hitting access is legal.
// Assumes: only a request with csr_en_i high is an access; legality needs
// machine privilege and the enhanced-protection strap.
module secfg_access_gate #(
    parameter int              ADDR_W   = 12,
    parameter logic [ADDR_W-1:0] CSR_ADDR = 12'h747
) (
    input  logic              en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [1:0]        priv_i,
    input  logic              feat_en_i,
    output logic              hit_o,
    output logic              read_ok_o,
    output logic              write_fire_o,
    output logic              illegal_o
);
    import secfg_pkg::*;

    logic permitted;

    // Address match and permission evaluation for the current request
    always_comb begin
        hit_o        = en_i && (addr_i == CSR_ADDR);
        permitted    = (priv_i == PRIV_MACHINE) && feat_en_i;
        read_ok_o    = hit_o && permitted;
        write_fire_o = hit_o && permitted && we_i;
        illegal_o    = hit_o && !permitted;
    end

endmodule

// File: rtl/secfg_lock_scan.sv
// Module: secfg_lock_scan
// Reports whether any protection entry currently has its lock bit set.
// Assumes: lock bits are stable in the cycle they are sampled.
module secfg_lock_scan #(
    parameter int NUM_ENTRIES = 16
) (
    input  logic [NUM_ENTRIES-1:0] lock_i,
    output logic                   any_locked_o
);
    logic [NUM_ENTRIES:0] chain;

    assign chain[0] = 1'b0;

    // OR chain across the entries, one stage per entry
    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_scan
        assign chain[g+1] = chain[g] | lock_i[g];
    end

    assign any_locked_o = chain[NUM_ENTRIES];

endmodule

// File: rtl/secfg_write_filter.sv
// Module: secfg_write_filter
// Computes the value to store for a write: reserved bits forced to zero,
// sticky flags merged, and the bypass raise suppressed while entries are locked.
// Assumes: old_i is the currently stored word.
module secfg_write_filter #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] old_i,
    input  logic [XLEN-1:0] wdata_i,
    input  logic            any_locked_i,
    output logic [XLEN-1:0] next_o
);
    import secfg_pkg::*;

    localparam logic [XLEN-1:0] WRITABLE = XLEN'((1 << FLAG_W) - 1);

    logic [XLEN-1:0] masked;
    secfg_flags_t    old_f;
    secfg_flags_t    new_f;
    secfg_flags_t    out_f;

    // Apply the write rules to each flag
    always_comb begin
        masked = wdata_i & WRITABLE;
        old_f  = secfg_flags_t'(old_i[FLAG_W-1:0]);
        new_f  = secfg_flags_t'(masked[FLAG_W-1:0]);
        out_f.lockdown  = new_f.lockdown  | old_f.lockdown;
        out_f.whitelist = new_f.whitelist | old_f.whitelist;
        out_f.bypass    = new_f.bypass & (old_f.bypass | !any_locked_i);
        next_o = masked;
        next_o[FLAG_W-1:0] = out_f;
    end

endmodule

// File: rtl/secfg_ctrl_reg.sv
// Module: secfg_ctrl_reg (top)
// Machine security configuration register: stores the lockdown, whitelist and
// bypass flags behind a CSR port, filters writes and flags illegal accesses.
// Assumes: synchronous active-low reset; writes land on the next rising edge.
module secfg_ctrl_reg #(
    parameter int                XLEN        = 32,
    parameter int                NUM_ENTRIES = 16,
    parameter int                ADDR_W      = 12,
    parameter logic [ADDR_W-1:0] CSR_ADDR    = 12'h747
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   csr_en_i,
    input  logic [ADDR_W-1:0]      csr_addr_i,
    input  logic                   csr_we_i,
    input  logic [XLEN-1:0]        csr_wdata_i,
    output logic [XLEN-1:0]        csr_rdata_o,
    output logic                   csr_illegal_o,
    input  logic [1:0]             priv_i,
    input  logic                   feat_en_i,
    input  logic [NUM_ENTRIES-1:0] entry_lock_i,
    output logic                   cfg_lockdown_o,
    output logic                   cfg_whitelist_o,
    output logic                   cfg_bypass_o,
    output logic                   cfg_update_o
);
    import secfg_pkg::*;

    logic [XLEN-1:0] cfg_q;
    logic [XLEN-1:0] cfg_d;
    logic            hit;
    logic            read_ok;
    logic            write_fire;
    logic            any_locked;
    logic            update_q;

    secfg_access_gate #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR)) u_gate (
        .en_i         (csr_en_i),
        .addr_i       (csr_addr_i),
        .we_i         (csr_we_i),
        .priv_i       (priv_i),
        .feat_en_i    (feat_en_i),
        .hit_o        (hit),
        .read_ok_o    (read_ok),
        .write_fire_o (write_fire),
        .illegal_o    (csr_illegal_o)
    );

    secfg_lock_scan #(.NUM_ENTRIES(NUM_ENTRIES)) u_scan (
        .lock_i       (entry_lock_i),
        .any_locked_o (any_locked)
    );

    secfg_write_filter #(.XLEN(XLEN)) u_filter (
        .old_i        (cfg_q),
        .wdata_i      (csr_wdata_i),
        .any_locked_i (any_locked),
        .next_o       (cfg_d)
    );

    // Register storage: cleared on reset, loaded on a legal write
    always_ff @(posedge clk) begin
        if (!rst_n)          cfg_q <= '0;
        else if (write_fire) cfg_q <= cfg_d;
    end

    // Update strobe: one cycle after each legal write
    always_ff @(posedge clk) begin
        if (!rst_n) update_q <= 1'b0;
        else        update_q <= write_fire;
    end

    // Read data and flag outputs
    always_comb begin
        csr_rdata_o     = read_ok ? cfg_q : '0;
        cfg_lockdown_o  = cfg_q[BIT_LOCKDOWN];
        cfg_whitelist_o = cfg_q[BIT_WHITELIST];
        cfg_bypass_o    = cfg_q[BIT_BYPASS];
        cfg_update_o    = update_q;
    end

endmodule

// File: rtl/secfg_ctrl_reg_chk.sv
// Module: secfg_ctrl_reg_chk
// Property checker for secfg_ctrl_reg, attached with bind below.
module secfg_ctrl_reg_chk #(
    parameter int XLEN        = 32,
    parameter int NUM_ENTRIES = 16
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   csr_en_i,
    input logic                   csr_we_i,
    input logic                   hit,
    input logic                   csr_illegal_o,
    input logic [XLEN-1:0]        csr_rdata_o,
    input logic [XLEN-1:0]        cfg_q,
    input logic [NUM_ENTRIES-1:0] entry_lock_i,
    input logic                   cfg_update_o
);
    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (cfg_q == '0) && !cfg_update_o); // R1
    AST_LOCKDOWN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) cfg_q[0] |=> cfg_q[0]); // R2
    AST_WHITELIST_STICKY: assert property (@(posedge clk) disable iff (!rst_n) cfg_q[1] |=> cfg_q[1]); // R3
    AST_BYPASS_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n) (!cfg_q[2] && (|entry_lock_i)) |=> !cfg_q[2]); // R4
    AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) csr_illegal_o |=> $stable(cfg_q)); // R6
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n) csr_rdata_o[XLEN-1:3] == '0); // R8
    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !hit |-> (!csr_illegal_o && csr_rdata_o == '0)); // R9
    AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !hit |=> $stable(cfg_q)); // R9
    AST_UPDATE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (csr_en_i && csr_we_i && hit && !csr_illegal_o) |=> cfg_update_o); // R10
    AST_UPDATE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) !(csr_en_i && csr_we_i && hit && !csr_illegal_o) |=> !cfg_update_o); // R10
endmodule

bind secfg_ctrl_reg secfg_ctrl_reg_chk #(.XLEN(XLEN), .NUM_ENTRIES(NUM_ENTRIES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .csr_en_i      (csr_en_i),
    .csr_we_i      (csr_we_i),
    .hit           (hit),
    .csr_illegal_o (csr_illegal_o),
    .csr_rdata_o   (csr_rdata_o),
    .cfg_q         (cfg_q),
    .entry_lock_i  (entry_lock_i),
    .cfg_update_o  (cfg_update_o)
);

// File: tb/test_secfg_ctrl_reg.sv
// Bench: near-exhaustive sweep of secfg_ctrl_reg with four protection entries.
module test_secfg_ctrl_reg;
    localparam int XLEN = 32;
    localparam int NE   = 4;
    localparam int AW   = 12;
    localparam logic [AW-1:0] ADDR = 12'h747;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            csr_en_i = 1'b0;
    logic [AW-1:0]   csr_addr_i = '0;
    logic            csr_we_i = 1'b0;
    logic [XLEN-1:0] csr_wdata_i = '0;
    logic [XLEN-1:0] csr_rdata_o;
    logic            csr_illegal_o;
    logic [1:0]      priv_i = 2'b11;
    logic            feat_en_i = 1'b1;
    logic [NE-1:0]   entry_lock_i = '0;
    logic            cfg_lockdown_o, cfg_whitelist_o, cfg_bypass_o, cfg_update_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    secfg_ctrl_reg #(.XLEN(XLEN), .NUM_ENTRIES(NE), .ADDR_W(AW), .CSR_ADDR(ADDR)) i_secfg_ctrl_reg (
        .clk(clk), .rst_n(rst_n), .csr_en_i(csr_en_i), .csr_addr_i(csr_addr_i),
        .csr_we_i(csr_we_i), .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
        .csr_illegal_o(csr_illegal_o), .priv_i(priv_i), .feat_en_i(feat_en_i),
        .entry_lock_i(entry_lock_i), .cfg_lockdown_o(cfg_lockdown_o),
        .cfg_whitelist_o(cfg_whitelist_o), .cfg_bypass_o(cfg_bypass_o),
        .cfg_update_o(cfg_update_o)
    );

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected stored value after a legal write, from the requirements
    function automatic logic [2:0] model(input logic [2:0] old, input logic [2:0] w, input logic locked);
        model[0] = w[0] | old[0];                  // R2
        model[1] = w[1] | old[1];                  // R3
        model[2] = w[2] & (old[2] | !locked);      // R4 / R5
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; csr_en_i = 1'b0; csr_we_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one write at negedge; check same-cycle outputs, then the strobe
    task automatic do_write(input logic [AW-1:0] a, input logic [XLEN-1:0] w,
                            input logic [1:0] pv, input logic fe,
                            input logic [2:0] old, input logic exp_legal);
        csr_en_i = 1'b1; csr_we_i = 1'b1; csr_addr_i = a; csr_wdata_i = w;
        priv_i = pv; feat_en_i = fe;
        #1;
        chk("R6 illegal flag", {31'b0, csr_illegal_o}, {31'b0, (a == ADDR) && !exp_legal});
        chk("R7 old value during write", csr_rdata_o, exp_legal ? {29'b0, old} : '0);
        @(negedge clk);
        csr_en_i = 1'b0; csr_we_i = 1'b0;
        #1;
        chk("R10 update strobe", {31'b0, cfg_update_o}, {31'b0, exp_legal});
    endtask

    task automatic do_read(input logic [2:0] exp);
        csr_en_i = 1'b1; csr_we_i = 1'b0; csr_addr_i = ADDR; priv_i = 2'b11; feat_en_i = 1'b1;
        #1;
        chk("R7/R8 read value", csr_rdata_o, {29'b0, exp});
        chk("R2/R3/R4 flag outputs", {29'b0, cfg_bypass_o, cfg_whitelist_o, cfg_lockdown_o}, {29'b0, exp});
        @(negedge clk);
        csr_en_i = 1'b0;
        #1;
        chk("R10 no strobe after read", {31'b0, cfg_update_o}, 32'b0);
        chk("R7 zero when idle", csr_rdata_o, '0);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++; n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R1 reset word", i_secfg_ctrl_reg.csr_rdata_o, '0);
        chk("R1 reset flags", {29'b0, cfg_bypass_o, cfg_whitelist_o, cfg_lockdown_o}, '0);
        chk("R1 reset strobe", {31'b0, cfg_update_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        do_read(3'b000);

        // R2 R3 R4 R5 R8: every start state x write value x lock pattern
        for (int s = 0; s < 8; s++) begin
            for (int w = 0; w < 8; w++) begin
                for (int l = 0; l < 16; l++) begin
                    logic [2:0] exp;
                    logic [XLEN-1:0] wd;
                    do_reset();
                    entry_lock_i = '0;
                    do_write(ADDR, XLEN'(s), 2'b11, 1'b1, 3'b000, 1'b1);
                    entry_lock_i = NE'(l);
                    exp = model(3'(s), 3'(w), l != 0);
                    wd  = (l[0] ? 32'hFFFF_FFF8 : 32'h0) | XLEN'(w);
                    do_write(ADDR, wd, 2'b11, 1'b1, 3'(s), 1'b1);
                    do_read(exp);
                end
            end
        end

        // R5: clear bypass, then re-set attempt with and without locks
        do_reset();
        entry_lock_i = '0;
        do_write(ADDR, 32'h4, 2'b11, 1'b1, 3'b000, 1'b1);
        entry_lock_i = 4'b0100;
        do_write(ADDR, 32'h0, 2'b11, 1'b1, 3'b100, 1'b1);
        do_read(3'b000);
        do_write(ADDR, 32'h4, 2'b11, 1'b1, 3'b000, 1'b1);
        do_read(3'b000); // R4 blocked re-set
        entry_lock_i = '0;
        do_write(ADDR, 32'h4, 2'b11, 1'b1, 3'b000, 1'b1);
        do_read(3'b100); // R5 allowed

        // R6: every privilege code and strap value
        for (int p = 0; p < 4; p++) begin
            for (int f = 0; f < 2; f++) begin
                logic legal;
                legal = (p == 3) && (f == 1);
                do_reset();
                entry_lock_i = '0;
                do_write(ADDR, 32'h7, 2'(p), 1'(f), 3'b000, legal);
                do_read(legal ? 3'b111 : 3'b000);
            end
        end

        // R9: other addresses and disabled requests have no effect
        for (int k = 0; k < 6; k++) begin
            logic [AW-1:0] a;
            a = ADDR ^ AW'(1 << k);
            do_reset();
            do_write(a, 32'h7, 2'b11, 1'b1, 3'b000, 1'b0);
            chk("R9 miss rdata", csr_rdata_o, '0);
            do_read(3'b000);
        end
        do_reset();
        @(negedge clk);
        csr_en_i = 1'b0; csr_we_i = 1'b1; csr_addr_i = ADDR; csr_wdata_i = 32'h7;
        #1;
        chk("R9 disabled no illegal", {31'b0, csr_illegal_o}, '0);
        @(negedge clk);
        csr_we_i = 1'b0;
        do_read(3'b000);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule